// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block is the internal data store of an 8-bit microcontroller core. It holds a 128-byte on-chip RAM and forwards accesses in the upper half of the direct address space to an external special-function register file. That file is reached through a plain byte-wide read/write port. One request port takes byte reads and writes in three address modes: direct, indirect and register-bank. It also takes single-bit reads and writes through an 8-bit bit address.

Each request is resolved to a byte address and a target, either RAM or the SFR port, in the same cycle. A read returns its result one clock later with a one-cycle valid strobe. A bit write runs as a read-modify-write: the byte is read and merged in the request cycle, then written back in the following cycle. During that write-back cycle a busy flag is high and any new request is dropped. Working registers R0 to R7 are relocated into one of four eight-byte banks at the bottom of RAM by a 2-bit bank select.

Top module: `idata_mem`

## Requirements
- R1: With req_mode = 0 (direct), an address below 128 accesses RAM. An address of 128 or above drives the SFR port: sfr_rd for a read or sfr_wr for a write, in the request cycle, with sfr_addr equal to the request address and sfr_wdata equal to req_wdata.
- R2: With req_mode = 1 (indirect), every address targets RAM and the SFR port stays idle. Addresses 128 to 255 have no storage: writes to them change no RAM byte, and reads from them return 8'h00.
- R3: With req_mode = 2 (register), operand Rn with n = req_addr[2:0] resolves to RAM address bank_sel*8 + n.
- R4: With req_mode = 3 (bit), a bit address below 128 selects RAM byte 32 + addr[6:3] and bit addr[2:0], where bit 0 is the least significant bit.
- R5: A bit address of 128 or above selects SFR byte {addr[7:3], 3'b000} and bit addr[2:0]. The access appears on the SFR port with sfr_addr[2:0] = 0.
- R6: A bit write replaces only the addressed bit with req_wdata[0] and leaves the other seven bits unchanged. For an SFR target, sfr_rd is high in the request cycle and sfr_wr is high in the next cycle, at the same sfr_addr and carrying the merged byte.
- R7: busy is high for exactly the one cycle after an accepted bit write. A request presented while busy is high is ignored: it has no read result, no write and no SFR strobe.
- R8: An accepted read sets rd_valid high for one cycle, starting one clock after the request. For a byte read rd_data carries the byte. For a bit read rd_data[0] carries the bit and rd_data[7:1] are 0. rd_data holds its value when no read is accepted.
- R9: After reset, rd_valid and busy are 0 and rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_en | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| req_addr | input | 8 | Byte address, register number (bits 2:0) or bit address |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| bank_sel | input | 2 | Register bank select |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Bit write-back in progress |
| sfr_addr | output | 8 | SFR byte address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write byte |
| sfr_rdata | input | 8 | SFR read byte, combinational from the register file |

## Verification
The bench builds the block with its default parameters: 128 RAM bytes and the bit window based at byte 32. These values put both edges of the RAM range within reach, namely byte 127 and the unimplemented byte 128 that sits beside it. They also make every bit address reachable, along with all four register banks and the SFR bytes with aligned addresses. A behavioural model of RAM and of the SFR file predicts the strobes, the read results and busy on every clock. This covers bit writes into both windows, requests issued during write-back, and stores to unimplemented addresses that must not alias onto real bytes.

// File: rtl/idata_mem.sv
module idata_mem #(
  parameter int RAM_BYTES = 128,
  parameter int BIT_BASE  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_en,
  input  logic       req_we,
  input  logic [1:0] req_mode,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [1:0] bank_sel,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic [7:0] sfr_addr,
  output logic       sfr_rd,
  output logic       sfr_wr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  localparam int RAW = $clog2(RAM_BYTES);
  localparam logic [8:0] RAM_LIM = 9'(RAM_BYTES);
  localparam logic [7:0] BIT_BYTE0 = 8'(BIT_BASE);
  localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_REG = 2'd2, M_BIT = 2'd3;

  logic [7:0] ram [RAM_BYTES];

  logic       accept, to_sfr, ram_hit, is_bit;
  logic [7:0] eff_addr, ram_rbyte, cur_byte, merged;
  logic [2:0] bpos;
  logic       wb_sfr;
  logic [7:0] wb_addr, wb_byte;

  assign accept = req_en && !busy;
  assign is_bit = (req_mode == M_BIT);
  assign bpos   = req_addr[2:0];

  always_comb begin
    to_sfr   = 1'b0;
    eff_addr = req_addr;
    case (req_mode)
      M_DIR: to_sfr = req_addr[7];
      M_IND: to_sfr = 1'b0;
      M_REG: eff_addr = {3'b000, bank_sel, req_addr[2:0]};
      default: begin
        if (req_addr[7]) begin
          eff_addr = {req_addr[7:3], 3'b000};
          to_sfr   = 1'b1;
        end else begin
          eff_addr = BIT_BYTE0 + {4'b0000, req_addr[6:3]};
        end
      end
    endcase
  end

  assign ram_hit   = ({1'b0, eff_addr} < RAM_LIM);
  assign ram_rbyte = ram_hit ? ram[eff_addr[RAW-1:0]] : 8'h00;
  assign cur_byte  = to_sfr ? sfr_rdata : ram_rbyte;

  always_comb begin
    merged       = cur_byte;
    merged[bpos] = req_wdata[0];
  end

  assign sfr_rd    = accept && to_sfr && (!req_we || is_bit);
  assign sfr_wr    = (accept && to_sfr && req_we && !is_bit) || (busy && wb_sfr);
  assign sfr_addr  = busy ? wb_addr : eff_addr;
  assign sfr_wdata = busy ? wb_byte : req_wdata;

  always_ff @(posedge clk) begin
    if (accept && req_we && !is_bit && !to_sfr && ram_hit)
      ram[eff_addr[RAW-1:0]] <= req_wdata;
    else if (busy && !wb_sfr)
      ram[wb_addr[RAW-1:0]] <= wb_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wb_sfr   <= 1'b0;
      wb_addr  <= 8'h00;
      wb_byte  <= 8'h00;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      busy     <= accept && req_we && is_bit;
      rd_valid <= accept && !req_we;
      if (accept && req_we && is_bit) begin
        wb_sfr  <= to_sfr;
        wb_addr <= eff_addr;
        wb_byte <= merged;
      end
      if (accept && !req_we)
        rd_data <= is_bit ? {7'b0, cur_byte[bpos]} : cur_byte;
    end
  end
endmodule

// File: rtl/idata_mem_chk.sv
module idata_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_en,
  input logic       req_we,
  input logic [1:0] req_mode,
  input logic [7:0] req_addr,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic [7:0] sfr_addr,
  input logic       sfr_rd,
  input logic       sfr_wr
);
  AST_SFR_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_rd && sfr_wr)); // R6
  AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !busy && req_mode == 2'd1) |-> (!sfr_rd && !sfr_wr)); // R2
  AST_SFR_BIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !busy && req_mode == 2'd3 && req_addr[7]) |-> (sfr_rd && sfr_addr[2:0] == 3'b000)); // R5
  AST_BIT_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !busy && req_we && req_mode == 2'd3) |=> busy); // R7
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R7
  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !busy && !req_we) |=> rd_valid); // R8
  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_en && !busy && !req_we)); // R8
  AST_BIT_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_mode) == 2'd3) |-> (rd_data[7:1] == 7'd0)); // R8
  AST_WB_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sfr_wr) |-> (sfr_addr == $past(sfr_addr))); // R6
endmodule

bind idata_mem idata_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
  .req_mode(req_mode), .req_addr(req_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .busy(busy), .sfr_addr(sfr_addr),
  .sfr_rd(sfr_rd), .sfr_wr(sfr_wr)
);

// File: tb/tb_idata_mem.sv
module tb_idata_mem;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_en = 1'b0, req_we = 1'b0;
  logic [1:0] req_mode = 2'd0, bank_sel = 2'd0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic       rd_valid, busy, sfr_rd, sfr_wr;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;

  idata_mem dut (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
    .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_sel(bank_sel), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] sfr_file [128];
  assign sfr_rdata = sfr_file[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_wr) sfr_file[sfr_addr[6:0]] <= sfr_wdata;

  logic [7:0] ram_ref [128];
  logic [7:0] sfr_ref [128];
  logic       m_busy = 1'b0, m_valid = 1'b0, m_wb_sfr = 1'b0;
  logic [7:0] m_data = 8'h00, m_wb_addr = 8'h00;
  int nchk = 0, nerr = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit en, bit we, logic [1:0] mode,
                      logic [7:0] addr, logic [7:0] wd, logic [1:0] bank);
    bit acc, sfr, exp_rd, exp_wr, nb;
    logic [7:0] ea, cur, mg;
    int bp;
    acc = en && !m_busy;
    sfr = 0;
    ea  = addr;
    bp  = int'(addr % 8);
    case (mode)
      2'd0: sfr = (addr >= 128);
      2'd1: sfr = 0;
      2'd2: ea = 8'(int'(bank) * 8 + int'(addr % 8));
      default: if (addr >= 128) begin ea = addr & 8'hF8; sfr = 1; end
               else ea = 8'(32 + int'(addr) / 8);
    endcase
    cur = sfr ? sfr_ref[ea[6:0]] : ((ea < 128) ? ram_ref[ea[6:0]] : 8'h00);
    mg = cur;
    mg[bp] = wd[0];
    req_en = en; req_we = we; req_mode = mode; req_addr = addr;
    req_wdata = wd; bank_sel = bank;
    #1;
    exp_rd = acc && sfr && (!we || mode == 2'd3);
    exp_wr = (acc && sfr && we && mode != 2'd3) || m_wb_sfr;
    chk(tag, "sfr_rd", sfr_rd, exp_rd);
    chk(tag, "sfr_wr", sfr_wr, exp_wr);
    if (exp_rd || exp_wr) chk(tag, "sfr_addr", sfr_addr, m_busy ? m_wb_addr : ea);
    if (exp_wr && !m_busy) chk(tag, "sfr_wdata", sfr_wdata, wd);
    @(posedge clk);
    @(negedge clk);
    nb = acc && we && mode == 2'd3;
    if (acc && !we) begin
      m_valid = 1;
      m_data = (mode == 2'd3) ? {7'b0, cur[bp]} : cur;
    end else m_valid = 0;
    if (acc && we) begin
      if (mode == 2'd3) begin
        if (sfr) sfr_ref[ea[6:0]] = mg; else ram_ref[ea[6:0]] = mg;
      end else if (sfr) sfr_ref[ea[6:0]] = wd;
      else if (ea < 128) ram_ref[ea[6:0]] = wd;
    end
    m_wb_sfr  = nb && sfr;
    m_wb_addr = ea;
    m_busy    = nb;
    chk(tag, "rd_valid", rd_valid, m_valid);
    chk(tag, "rd_data", rd_data, m_data);
    chk(tag, "busy", busy, m_busy);
    req_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      sfr_file[i] = 8'(i * 3 + 1);
      sfr_ref[i]  = 8'(i * 3 + 1);
    end
    #(CLK_PERIOD * 2 + 2);
    chk("R9", "rd_valid", rd_valid, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "rd_data", rd_data, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 128; i++) step("R2", 1, 1, 2'd1, 8'(i), 8'(i) ^ 8'h5A, 2'd0);
    for (int i = 0; i < 128; i += 9) step("R2", 1, 0, 2'd1, 8'(i), 0, 2'd0);
    step("R2", 1, 0, 2'd1, 8'd127, 0, 2'd0);
    step("R2", 1, 1, 2'd1, 8'd200, 8'hFF, 2'd0);
    step("R2", 1, 1, 2'd1, 8'd128, 8'hEE, 2'd0);
    step("R2", 1, 0, 2'd1, 8'd200, 0, 2'd0);
    step("R2", 1, 0, 2'd1, 8'd72, 0, 2'd0);
    step("R2", 1, 0, 2'd1, 8'd0, 0, 2'd0);

    step("R1", 1, 0, 2'd0, 8'h10, 0, 2'd0);
    step("R1", 1, 1, 2'd0, 8'h7F, 8'hC3, 2'd0);
    step("R1", 1, 0, 2'd0, 8'h7F, 0, 2'd0);
    step("R1", 1, 1, 2'd0, 8'h90, 8'hA5, 2'd0);
    step("R1", 1, 0, 2'd0, 8'h90, 0, 2'd0);
    step("R1", 1, 0, 2'd0, 8'hF0, 0, 2'd0);
    step("R1", 1, 0, 2'd1, 8'h10, 0, 2'd0);

    for (int b = 0; b < 4; b++) begin
      step("R3", 1, 1, 2'd2, 8'd5, 8'(8'h30 + b), 2'(b));
      step("R3", 1, 0, 2'd1, 8'(b * 8 + 5), 0, 2'd0);
      step("R3", 1, 0, 2'd2, 8'hFD, 0, 2'(b));
    end

    for (int a = 0; a < 128; a += 13) step("R4", 1, 0, 2'd3, 8'(a), 0, 2'd0);
    step("R4", 1, 0, 2'd3, 8'd127, 0, 2'd0);
    step("R6", 1, 1, 2'd3, 8'd19, 8'h01, 2'd0);
    step("R6", 0, 0, 2'd0, 8'd0, 0, 2'd0);
    step("R6", 1, 0, 2'd1, 8'd34, 0, 2'd0);
    step("R6", 1, 1, 2'd3, 8'd20, 8'hFE, 2'd0);
    step("R6", 1, 0, 2'd1, 8'd34, 0, 2'd0);
    step("R6", 1, 0, 2'd3, 8'd19, 0, 2'd0);

    step("R5", 1, 0, 2'd3, 8'hE3, 0, 2'd0);
    step("R5", 1, 1, 2'd3, 8'hE3, 8'h01, 2'd0);
    step("R5", 0, 0, 2'd0, 8'd0, 0, 2'd0);
    step("R5", 1, 0, 2'd0, 8'hE0, 0, 2'd0);
    step("R6", 1, 1, 2'd3, 8'hFF, 8'h00, 2'd0);
    step("R6", 0, 0, 2'd0, 8'd0, 0, 2'd0);
    step("R6", 1, 0, 2'd0, 8'hF8, 0, 2'd0);
    step("R5", 1, 0, 2'd3, 8'h87, 0, 2'd0);

    step("R7", 1, 1, 2'd3, 8'd0, 8'h00, 2'd0);
    step("R7", 1, 1, 2'd1, 8'd50, 8'h99, 2'd0);
    step("R7", 1, 0, 2'd1, 8'd50, 0, 2'd0);
    step("R7", 1, 1, 2'd3, 8'hC1, 8'h01, 2'd0);
    step("R7", 1, 1, 2'd0, 8'hA0, 8'h77, 2'd0);
    step("R7", 1, 0, 2'd0, 8'hA0, 0, 2'd0);
    step("R7", 1, 1, 2'd3, 8'd9, 8'h01, 2'd0);
    step("R7", 1, 0, 2'd1, 8'd33, 0, 2'd0);
    step("R7", 1, 0, 2'd1, 8'd33, 0, 2'd0);

    step("R8", 1, 0, 2'd1, 8'd77, 0, 2'd0);
    step("R8", 0, 0, 2'd0, 8'd0, 0, 2'd0);
    step("R8", 0, 1, 2'd1, 8'd77, 8'h11, 2'd0);
    step("R8", 1, 1, 2'd1, 8'd78, 8'h22, 2'd0);
    step("R8", 1, 0, 2'd3, 8'd1, 0, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule